// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Bank

This block gathers hardware event pulses from three sources (receive, transmit and miscellaneous) into three cause banks and turns them into one interrupt line. Each bank has a latched cause word, a mask word with separate set and clear write ports, a software port that raises cause bits, and a per-bit mode word. The mode word chooses, for each bit, whether the bit clears when software reads the cause word or only when software writes a 1 to it.

A summary block above the banks holds one pending bit per bank. A bank drives its summary bit while any of its unmasked cause bits is set. The summary word clears when read and has its own full-word mask. The interrupt output is high while any summary bit is set and not masked. Software reaches all of this through a simple word-addressed read and write port. Read data is returned one cycle after the read strobe.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset every cause word is 0, every bank mask reads 0xFFFFFFFF, every mode word is 0, the summary mask reads 0xFFFFFFFF, and the interrupt output is low.
- R2: A 1 on a bit of a bank's event input sets that cause bit on the next clock edge. The bit stays set until software clears it.
- R3: Writing a word to a bank's mask-set register (word offset 1) sets the mask bits where the word is 1. Writing to the mask-clear register (offset 2) clears the mask bits where the word is 1. Bits written as 0 keep their value. The mask-value register (offset 5, read only) returns the current mask.
- R4: A cause bit whose mode bit is 0 is not changed by a read of the cause register (offset 0). It clears when software writes a 1 to it there. Writing a 0 to it has no effect.
- R5: A cause bit whose mode bit is 1 clears on a read of the cause register, and that read still returns the bit as set. The mode register (offset 4) sets the mode of each bit separately. With a mode word of 0xF7FFFFFF, bit 27 keeps write-one-to-clear behaviour while bit 0 clears on read.
- R6: Writing a 1 to a bit of the cause-set register (offset 3) sets that cause bit with no hardware event.
- R7: An event on a cause bit in the same cycle as a read or write that clears it wins, and the bit stays set.
- R8: Summary bit k (receive = bit 0, transmit = bit 1, miscellaneous = bit 2; summary register at word address 24) is set one edge after bank k has any cause bit that is set and unmasked. Masked cause bits do not contribute.
- R9: A read of the summary register clears it and returns the value from before the clear. A bank that is still pending sets its bit again on that same edge.
- R10: The summary mask (word address 25) is written as a full word. The interrupt output is high exactly while some summary bit k is set and summary mask bit k is 0.
- R11: Read data appears on the edge that samples the read strobe. Write-only and unmapped offsets read as 0, and writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_evt_i | input | 96 | Event pulses, bank k in bits [32k+31:32k] |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 5 | Word address: bank in [4:3] (3 = summary), register in [2:0] |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt output |

## Verification
The in-design assertions assume a read strobe and a write strobe are never active in the same cycle. They also assume event inputs are single-cycle pulses, which may coincide with software access. The bench drives every bus transfer from a task that asserts only one strobe at a time, and it raises events either alone or deliberately next to a clearing access when it probes the race case. Every pending and interrupt check is sampled at least one edge after the write that opened or closed a mask, because the summary word adds one register stage.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int IRQ_NBANK = 3;
    localparam int IRQ_DW    = 32;
    localparam int IRQ_REG_W = 3;
    localparam int IRQ_BLK_W = $clog2(IRQ_NBANK + 1);
    localparam int IRQ_AW    = IRQ_BLK_W + IRQ_REG_W;

    // register selectors inside a bank
    localparam logic [IRQ_REG_W-1:0] REG_CAUSE = 3'd0;
    localparam logic [IRQ_REG_W-1:0] REG_MSET  = 3'd1;
    localparam logic [IRQ_REG_W-1:0] REG_MCLR  = 3'd2;
    localparam logic [IRQ_REG_W-1:0] REG_CSET  = 3'd3;
    localparam logic [IRQ_REG_W-1:0] REG_MODE  = 3'd4;
    localparam logic [IRQ_REG_W-1:0] REG_MVAL  = 3'd5;

    // register selectors inside the summary block
    localparam logic [IRQ_REG_W-1:0] SUM_CAUSE = 3'd0;
    localparam logic [IRQ_REG_W-1:0] SUM_MASK  = 3'd1;
endpackage

// File: rtl/irq_cause_bank.sv
module irq_cause_bank
    import irq_bank_pkg::*;
#(
    parameter int DW = IRQ_DW
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [DW-1:0]        evt_i,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [IRQ_REG_W-1:0] reg_i,
    input  logic [DW-1:0]        wdata_i,
    output logic [DW-1:0]        rdata_o,
    output logic                 pending_o
);
    typedef struct packed {
        logic [DW-1:0] cause;
        logic [DW-1:0] mask;
        logic [DW-1:0] mode;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [DW-1:0] clr_bits, set_bits;
    logic          cause_rd, cause_acc;

    assign cause_rd  = sel_i && rd_i && (reg_i == REG_CAUSE);
    assign cause_acc = sel_i && (rd_i || wr_i) && (reg_i == REG_CAUSE);

    always_comb begin
        st_d     = st_q;
        clr_bits = '0;
        set_bits = '0;
        if (cause_rd) begin
            clr_bits = clr_bits | st_q.mode;
        end
        if (sel_i && wr_i) begin
            case (reg_i)
                REG_CAUSE: clr_bits = clr_bits | (wdata_i & ~st_q.mode);
                REG_MSET:  st_d.mask = st_q.mask | wdata_i;
                REG_MCLR:  st_d.mask = st_q.mask & ~wdata_i;
                REG_CSET:  set_bits = wdata_i;
                REG_MODE:  st_d.mode = wdata_i;
                default:   ;
            endcase
        end
        // events are ORed in last so they win over a clear
        st_d.cause = (st_q.cause & ~clr_bits) | set_bits | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.cause <= '0;
            st_q.mask  <= '1;
            st_q.mode  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_i)
            REG_CAUSE: rdata_o = st_q.cause;
            REG_MODE:  rdata_o = st_q.mode;
            REG_MVAL:  rdata_o = st_q.mask;
            default:   rdata_o = '0;
        endcase
    end

    assign pending_o = |(st_q.cause & ~st_q.mask);

    // R2 R7
    evt_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((st_q.cause & $past(evt_i)) == $past(evt_i)));

    // R3
    mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && reg_i == REG_MSET) |=> ((st_q.mask & $past(wdata_i)) == $past(wdata_i)));

    // R3
    mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i && wr_i && reg_i == REG_MCLR) |=> ((st_q.mask & $past(wdata_i)) == '0));

    // R4
    cause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cause_acc |=> ((st_q.cause & $past(st_q.cause)) == $past(st_q.cause)));

    // R5
    cor_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cause_rd && !wr_i) |=> ((st_q.cause & $past(st_q.mode & ~evt_i)) == '0));
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_bank_pkg::*;
#(
    parameter int NB = IRQ_NBANK,
    parameter int DW = IRQ_DW
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [NB-1:0]        pending_i,
    input  logic                 sel_i,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [IRQ_REG_W-1:0] reg_i,
    input  logic [DW-1:0]        wdata_i,
    output logic [DW-1:0]        rdata_o,
    output logic                 irq_o
);
    typedef struct packed {
        logic [NB-1:0] pcause;
        logic [DW-1:0] pmask;
    } sum_st_t;

    sum_st_t st_d, st_q;
    logic    pc_rd, pm_wr;

    assign pc_rd = sel_i && rd_i && (reg_i == SUM_CAUSE);
    assign pm_wr = sel_i && wr_i && (reg_i == SUM_MASK);

    always_comb begin
        st_d = st_q;
        if (pc_rd) begin
            st_d.pcause = '0;
        end
        st_d.pcause = st_d.pcause | pending_i;
        if (pm_wr) begin
            st_d.pmask = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.pcause <= '0;
            st_q.pmask  <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_i)
            SUM_CAUSE: rdata_o = DW'(st_q.pcause);
            SUM_MASK:  rdata_o = st_q.pmask;
            default:   rdata_o = '0;
        endcase
    end

    assign irq_o = |(st_q.pcause & ~st_q.pmask[NB-1:0]);

    // R8
    pend_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|pending_i) |=> ((st_q.pcause & $past(pending_i)) == $past(pending_i)));

    // R9
    sum_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_rd && pending_i == '0) |=> (st_q.pcause == '0));

    // R10
    pmask_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pm_wr |=> (st_q.pmask == $past(wdata_i)));

    // R10
    irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> (st_q.pcause != '0));
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irq_bank_pkg::*;
(
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [IRQ_NBANK*IRQ_DW-1:0] hw_evt_i,
    input  logic                        wr_i,
    input  logic                        rd_i,
    input  logic [IRQ_AW-1:0]           addr_i,
    input  logic [IRQ_DW-1:0]           wdata_i,
    output logic [IRQ_DW-1:0]           rdata_o,
    output logic                        irq_o
);
    localparam int NB = IRQ_NBANK;
    localparam int DW = IRQ_DW;
    localparam logic [IRQ_BLK_W-1:0] SUM_BLK = IRQ_BLK_W'(NB);

    logic [IRQ_BLK_W-1:0] blk;
    logic [IRQ_REG_W-1:0] regsel;
    logic [DW-1:0]        bank_rdata [NB];
    logic [NB-1:0]        bank_pend;
    logic [DW-1:0]        sum_rdata;
    logic [DW-1:0]        rdata_d, rdata_q;

    assign blk    = addr_i[IRQ_AW-1 -: IRQ_BLK_W];
    assign regsel = addr_i[IRQ_REG_W-1:0];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        irq_cause_bank #(.DW(DW)) u_bank (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .evt_i     (hw_evt_i[g*DW +: DW]),
            .sel_i     (blk == IRQ_BLK_W'(g)),
            .wr_i      (wr_i),
            .rd_i      (rd_i),
            .reg_i     (regsel),
            .wdata_i   (wdata_i),
            .rdata_o   (bank_rdata[g]),
            .pending_o (bank_pend[g])
        );
    end

    irq_summary #(.NB(NB), .DW(DW)) u_sum (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pending_i (bank_pend),
        .sel_i     (blk == SUM_BLK),
        .wr_i      (wr_i),
        .rd_i      (rd_i),
        .reg_i     (regsel),
        .wdata_i   (wdata_i),
        .rdata_o   (sum_rdata),
        .irq_o     (irq_o)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_i) begin
            rdata_d = '0;
            if (blk == SUM_BLK) begin
                rdata_d = sum_rdata;
            end
            for (int b = 0; b < NB; b++) begin
                if (blk == IRQ_BLK_W'(b)) begin
                    rdata_d = bank_rdata[b];
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rdata_d;
        end
    end

    assign rdata_o = rdata_q;

    // R11
    rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: tb/irq_cause_ctrl_test.sv
module irq_cause_ctrl_test;
    localparam int    DW  = 32;
    localparam int    NB  = 3;
    localparam time   TCK = 8ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NB*DW-1:0]  evt = '0;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [4:0]        addr = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [DW-1:0] exp;
        string         tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    logic      rd_fire = 1'b0;

    always #(TCK/2) clk = ~clk;

    irq_cause_ctrl uut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .hw_evt_i (evt),
        .wr_i     (wr),
        .rd_i     (rd),
        .addr_i   (addr),
        .wdata_i  (wdata),
        .rdata_o  (rdata),
        .irq_o    (irq)
    );

    function automatic logic [4:0] ra(int blk, int r);
        return 5'(blk * 8 + r);
    endfunction

    // monitor: a read sampled on an edge shows its data at the next negedge
    always @(posedge clk) rd_fire <= rd;

    always @(negedge clk) begin
        if (rd_fire) begin
            exp_item_t it;
            it = exp_q.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                fails++;
                $display("FAIL %s: rdata actual=%08h expected=%08h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic wr_reg(logic [4:0] a, logic [DW-1:0] d);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(logic [4:0] a, logic [DW-1:0] e, string tag);
        exp_item_t it;
        it.exp = e; it.tag = tag;
        exp_q.push_back(it);
        rd = 1'b1; addr = a;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic pulse(int b, logic [DW-1:0] bits);
        evt[b*DW +: DW] = bits;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic chk_irq(logic e, string tag);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq actual=%0b expected=%0b", tag, irq, e);
        end
    endtask

    initial begin
        #(TCK * 100000);
        fails++;
        $display("FAIL watchdog (all requirements): actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_reg(ra(0, 5), 32'hFFFF_FFFF, "R1 bank0 mask");
        rd_reg(ra(2, 4), 32'h0, "R1 bank2 mode");
        rd_reg(ra(1, 0), 32'h0, "R1 bank1 cause");
        rd_reg(ra(3, 1), 32'hFFFF_FFFF, "R1 summary mask");
        chk_irq(1'b0, "R1 irq");

        // R2 event latch, R4 read does not clear in W1C mode
        pulse(0, 32'h3);
        rd_reg(ra(0, 0), 32'h3, "R2 bank0 cause latched");
        rd_reg(ra(0, 0), 32'h3, "R4 read leaves W1C bits");
        rd_reg(ra(3, 0), 32'h0, "R8 masked causes not pending");
        chk_irq(1'b0, "R10 masked irq");

        // R3 mask set/clear
        wr_reg(ra(0, 2), 32'h1);
        rd_reg(ra(0, 5), 32'hFFFF_FFFE, "R3 mask clear bit0");
        rd_reg(ra(3, 0), 32'h1, "R8 bank0 summary bit");
        rd_reg(ra(3, 0), 32'h1, "R9 still pending re-sets");
        wr_reg(ra(0, 1), 32'h0);
        rd_reg(ra(0, 5), 32'hFFFF_FFFE, "R3 zero mask-set keeps mask");
        chk_irq(1'b0, "R10 summary masked");

        // R10 summary mask
        wr_reg(ra(3, 1), 32'hFFFF_FFF8);
        chk_irq(1'b1, "R10 irq after unmask");
        rd_reg(ra(3, 1), 32'hFFFF_FFF8, "R10 summary mask value");

        // R4 write-one-to-clear
        wr_reg(ra(0, 0), 32'h2);
        rd_reg(ra(0, 0), 32'h1, "R4 W1C clears bit1");
        wr_reg(ra(0, 0), 32'h0);
        rd_reg(ra(0, 0), 32'h1, "R4 write zero no effect");
        wr_reg(ra(0, 0), 32'h1);
        rd_reg(ra(0, 0), 32'h0, "R4 W1C clears bit0");
        chk_irq(1'b1, "R9 summary still latched");
        rd_reg(ra(3, 0), 32'h1, "R9 read returns latched");
        rd_reg(ra(3, 0), 32'h0, "R9 cleared by read");
        chk_irq(1'b0, "R10 irq drops");

        // R5 per-bit clear-on-read
        wr_reg(ra(2, 4), 32'hF7FF_FFFF);
        rd_reg(ra(2, 4), 32'hF7FF_FFFF, "R5 mode value");
        pulse(2, 32'h0800_0001);
        rd_reg(ra(2, 0), 32'h0800_0001, "R5 read returns before clear");
        rd_reg(ra(2, 0), 32'h0800_0000, "R5 bit0 cleared bit27 kept");
        wr_reg(ra(2, 0), 32'h0800_0000);
        rd_reg(ra(2, 0), 32'h0, "R5 bit27 cleared by write");

        // R6 software set, R8 transmit bit
        wr_reg(ra(1, 3), 32'h10);
        rd_reg(ra(1, 0), 32'h10, "R6 cause-set");
        wr_reg(ra(1, 2), 32'h10);
        rd_reg(ra(1, 5), 32'hFFFF_FFEF, "R3 bank1 mask");
        rd_reg(ra(3, 0), 32'h2, "R8 bank1 summary bit");
        chk_irq(1'b1, "R10 irq from bank1");
        wr_reg(ra(1, 0), 32'h10);
        rd_reg(ra(3, 0), 32'h2, "R9 latched after clear");
        rd_reg(ra(3, 0), 32'h0, "R9 cleared");
        chk_irq(1'b0, "R10 irq low again");

        // R7 event races a clear-on-read
        pulse(2, 32'h1);
        begin
            exp_item_t it;
            it.exp = 32'h1; it.tag = "R7 race read value";
            exp_q.push_back(it);
            rd = 1'b1; addr = ra(2, 0); evt[2*DW +: DW] = 32'h1;
            @(negedge clk);
            rd = 1'b0; evt = '0;
        end
        rd_reg(ra(2, 0), 32'h1, "R7 event wins over read clear");
        rd_reg(ra(2, 0), 32'h0, "R5 next read clears");
        // R7 event races a write-one-to-clear
        pulse(0, 32'h2);
        wr = 1'b1; addr = ra(0, 0); wdata = 32'h2; evt[0 +: DW] = 32'h2;
        @(negedge clk);
        wr = 1'b0; wdata = '0; evt = '0;
        rd_reg(ra(0, 0), 32'h2, "R7 event wins over W1C");

        // R11 unmapped and write-only
        rd_reg(ra(0, 1), 32'h0, "R11 write-only reads zero");
        rd_reg(ra(3, 7), 32'h0, "R11 unmapped reads zero");
        wr_reg(ra(3, 6), 32'h0000_0000);
        rd_reg(ra(3, 1), 32'hFFFF_FFF8, "R11 unmapped write ignored");
        rd_reg(ra(0, 7), 32'h0, "R11 bank unmapped");

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule